// File: doc/BRIEF.md
# Leaf Page-Table Entry Checker

This block takes a leaf page-table entry that a page walker has already fetched and decides whether the access that caused the walk may use it. It runs the legality and permission tests in a fixed priority order and reports either a pass or the first fault that applies. On a pass it also returns the translated physical address and the read, write and execute grants to load into a TLB entry. On a fault the address and the grants are forced to zero.

The tests cover several cases. A superpage whose page number has stray low bits is rejected. A nonzero memory-type field is rejected when the system has no page-based memory types. Two R/W/X encodings are reserved and are rejected. The user/supervisor page ownership is checked against the current mode, the SUM control and the access kind. The access must have the permission it needs. Contiguous-page (NAPOT) entries must use the single supported size and must sit at the last level.

The request is combinational into one register stage. A response appears exactly one cycle after each request. The walker, the accessed/dirty bit update and the TLB are outside this block.

Top module: `pte_leaf_checker`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. All `rsp_*` outputs keep their values while no request arrives. Reset clears `rsp_valid`, `rsp_fault`, `rsp_cause`, the address and the grants.
- R2: The PPN is PTE bits [53:10]. With level L (0 is the root, LEVELS-1 is the last level), any set bit among the low (LEVELS-1-L)*9 PPN bits gives a fault with cause 1.
- R3: PTE bits [62:61] form the memory-type field. When this field is nonzero and `req_memtype_ok` is 0, the result is a fault with cause 2.
- R4: PTE bits R=1, W=2 and X=3 select the permissions. W alone gives cause 3. W with X and without R gives cause 4.
- R5: A page with U (bit 4) set, accessed in S mode (`req_smode`=1), faults with cause 5. The exception is when `req_sum` is 1 and the access is not a fetch.
- R6: A page with U clear, accessed in U mode (`req_smode`=0), faults with cause 6.
- R7: `req_acc` encodes the access kind: 00 is a load, 01 a store and 10 a fetch. A load needs R, or X with `req_mxr` set (cause 7 if missing). A store needs W (cause 8). A fetch needs X (cause 9).
- R8: With NAPOT support built in and the N bit (63) set, the count of trailing zeros of the PPN plus one must equal 4, and the level must be the last. Otherwise the result is a fault with cause 10.
- R9: When several tests fail, the reported cause is the lowest-numbered one, in the order 1 through 10. A pass reports cause 0 and `rsp_fault`=0.
- R10: On a pass, the physical page number has three parts ORed together: the PPN with the NAPOT low 4 bits cleared, the virtual page number's NAPOT bits, and the VPN bits below the superpage shift. The page offset is `req_vaddr[11:0]`.
- R11: On a pass, `rsp_rd` = R or (X and MXR) and `rsp_ex` = X. `rsp_wr` = W and (store or D), where D is bit 7.
- R12: On a fault, `rsp_paddr`, `rsp_rd`, `rsp_wr` and `rsp_ex` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A leaf entry is presented this cycle |
| req_pte | input | 64 | Leaf page-table entry |
| req_level | input | 2 | Level at which the leaf was found, 0 = root |
| req_vaddr | input | 39 | Virtual address being translated |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| req_smode | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_sum | input | 1 | Supervisor may touch user pages |
| req_mxr | input | 1 | Executable pages are also readable |
| req_memtype_ok | input | 1 | Page-based memory types are supported |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access faults |
| rsp_cause | output | 4 | First failing test, 0 on pass |
| rsp_paddr | output | 56 | Physical address on pass |
| rsp_rd | output | 1 | Read grant for the TLB fill |
| rsp_wr | output | 1 | Write grant for the TLB fill |
| rsp_ex | output | 1 | Execute grant for the TLB fill |

## Verification
The assertions take three things for granted about the inputs. A request never carries access code 11. The level is always below LEVELS. The walker hands over only leaf entries, meaning V is set and at least one of R, W and X is set. The input-legality assertions guard the first two.

The stimulus, both directed and random, draws the access kind from the three legal codes and the level from 0 to 2. It always sets V and picks a nonzero R/W/X field. It then varies the PPN alignment, the memory-type field, the N bit and the mode controls freely, so that several faults overlap and the priority order is exercised.

// File: rtl/pte_leaf_pkg.sv
package pte_leaf_pkg;

   // Access kind encoding
   localparam logic [1:0] ACC_LOAD  = 2'b00;
   localparam logic [1:0] ACC_STORE = 2'b01;
   localparam logic [1:0] ACC_FETCH = 2'b10;

   // Entry bit positions
   localparam int PB_V      = 0;
   localparam int PB_R      = 1;
   localparam int PB_W      = 2;
   localparam int PB_X      = 3;
   localparam int PB_U      = 4;
   localparam int PB_D      = 7;
   localparam int PB_PPN_LO = 10;
   localparam int PB_MT_LO  = 61;
   localparam int MT_W      = 2;
   localparam int PB_N      = 63;

   // Fault causes in priority order
   typedef enum logic [3:0] {
      FLT_NONE     = 4'd0,
      FLT_MISALIGN = 4'd1,
      FLT_MEMTYPE  = 4'd2,
      FLT_RSVD_W   = 4'd3,
      FLT_RSVD_WX  = 4'd4,
      FLT_USER_PG  = 4'd5,
      FLT_SUPV_PG  = 4'd6,
      FLT_NO_READ  = 4'd7,
      FLT_NO_WRITE = 4'd8,
      FLT_NO_EXEC  = 4'd9,
      FLT_NAPOT    = 4'd10
   } fault_e;

endpackage

// File: rtl/pte_leaf_align.sv
module pte_leaf_align #(
   parameter int PPN_W    = 44,
   parameter int IDX_BITS = 9,
   parameter int LEVELS   = 3,
   localparam int LVL_W   = $clog2(LEVELS)
) (
   input  logic [PPN_W-1:0] ppn,
   input  logic [LVL_W-1:0] level,
   output logic [PPN_W-1:0] shift_mask,
   output logic             misaligned
);

   logic [PPN_W-1:0] lvl_mask [LEVELS];

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int SH = (LEVELS - 1 - l) * IDX_BITS;
      if (SH == 0) begin : g_leaf
         assign lvl_mask[l] = '0;
      end else begin : g_super
         assign lvl_mask[l] = {PPN_W{1'b1}} >> (PPN_W - SH);
      end
   end

   always_comb begin
      shift_mask = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (level == LVL_W'(l)) shift_mask = lvl_mask[l];
      end
   end

   assign misaligned = |(ppn & shift_mask);

endmodule

// File: rtl/pte_leaf_napot.sv
module pte_leaf_napot #(
   parameter int  PPN_W     = 44,
   parameter int  LEVELS    = 3,
   parameter int  NAPOT_LOG = 4,
   parameter bit  NAPOT_EN  = 1'b1,
   localparam int LVL_W     = $clog2(LEVELS),
   localparam int CTZ_W     = $clog2(PPN_W + 1)
) (
   input  logic [PPN_W-1:0] ppn,
   input  logic [LVL_W-1:0] level,
   input  logic             n_bit,
   output logic             napot_bad,
   output logic [PPN_W-1:0] napot_mask
);

   if (NAPOT_EN) begin : g_napot
      logic [CTZ_W-1:0] tz;
      logic             size_ok;
      logic             last_lvl;

      always_comb begin
         tz = CTZ_W'(PPN_W);
         for (int i = PPN_W - 1; i >= 0; i--) begin
            if (ppn[i]) tz = CTZ_W'(i);
         end
      end

      assign size_ok    = (tz == CTZ_W'(NAPOT_LOG - 1));
      assign last_lvl   = (level == LVL_W'(LEVELS - 1));
      assign napot_bad  = n_bit && !(size_ok && last_lvl);
      assign napot_mask = n_bit ? PPN_W'((1 << NAPOT_LOG) - 1) : '0;
   end else begin : g_plain
      logic unused_napot;
      assign unused_napot = ^{ppn, level, n_bit};
      assign napot_bad    = 1'b0;
      assign napot_mask   = '0;
   end

endmodule

// File: rtl/pte_leaf_rules.sv
module pte_leaf_rules
   import pte_leaf_pkg::*;
(
   input  logic        bit_r,
   input  logic        bit_w,
   input  logic        bit_x,
   input  logic        bit_u,
   input  logic        bit_d,
   input  logic        memtype_set,
   input  logic        memtype_ok,
   input  logic [1:0]  acc,
   input  logic        smode,
   input  logic        sum,
   input  logic        mxr,
   input  logic        misaligned,
   input  logic        napot_bad,
   output fault_e      cause,
   output logic        grant_rd,
   output logic        grant_wr,
   output logic        grant_ex
);

   logic [2:0] xwr;
   logic       is_load, is_store, is_fetch;
   logic       user_bad, supv_bad;

   assign xwr      = {bit_x, bit_w, bit_r};
   assign is_load  = (acc == ACC_LOAD);
   assign is_store = (acc == ACC_STORE);
   assign is_fetch = (acc == ACC_FETCH);
   assign user_bad = bit_u && smode && !(sum && !is_fetch);
   assign supv_bad = !bit_u && !smode;

   always_comb begin
      cause = FLT_NONE;
      if (misaligned)                                cause = FLT_MISALIGN;
      else if (memtype_set && !memtype_ok)           cause = FLT_MEMTYPE;
      else if (xwr == 3'b010)                        cause = FLT_RSVD_W;
      else if (xwr == 3'b110)                        cause = FLT_RSVD_WX;
      else if (user_bad)                             cause = FLT_USER_PG;
      else if (supv_bad)                             cause = FLT_SUPV_PG;
      else if (is_load && !(bit_r || (bit_x && mxr))) cause = FLT_NO_READ;
      else if (is_store && !bit_w)                   cause = FLT_NO_WRITE;
      else if (is_fetch && !bit_x)                   cause = FLT_NO_EXEC;
      else if (napot_bad)                            cause = FLT_NAPOT;
   end

   assign grant_rd = bit_r || (bit_x && mxr);
   assign grant_ex = bit_x;
   assign grant_wr = bit_w && (is_store || bit_d);

endmodule

// File: rtl/pte_leaf_checker.sv
module pte_leaf_checker
   import pte_leaf_pkg::*;
#(
   parameter int  PTE_W      = 64,
   parameter int  PPN_W      = 44,
   parameter int  VA_W       = 39,
   parameter int  PAGE_SHIFT = 12,
   parameter int  LEVELS     = 3,
   parameter int  IDX_BITS   = 9,
   parameter int  NAPOT_LOG  = 4,
   parameter bit  NAPOT_EN   = 1'b1,
   localparam int LVL_W      = $clog2(LEVELS),
   localparam int PA_W       = PPN_W + PAGE_SHIFT,
   localparam int VPN_W      = VA_W - PAGE_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [PTE_W-1:0] req_pte,
   input  logic [LVL_W-1:0] req_level,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_acc,
   input  logic             req_smode,
   input  logic             req_sum,
   input  logic             req_mxr,
   input  logic             req_memtype_ok,
   output logic             rsp_valid,
   output logic             rsp_fault,
   output logic [3:0]       rsp_cause,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_rd,
   output logic             rsp_wr,
   output logic             rsp_ex
);

   // Elaboration-time parameter checks
   if (LEVELS < 2) begin : g_bad_levels
      $error("LEVELS must be at least 2");
   end
   if (PTE_W <= PB_N) begin : g_bad_pte
      $error("PTE_W too narrow for the entry layout");
   end
   if (PB_PPN_LO + PPN_W > PB_MT_LO) begin : g_bad_ppn
      $error("PPN_W overlaps the memory-type field");
   end
   if (VPN_W > PPN_W || VPN_W < LEVELS * IDX_BITS) begin : g_bad_va
      $error("VA_W inconsistent with PPN_W, LEVELS and IDX_BITS");
   end
   if (NAPOT_LOG < 1 || NAPOT_LOG > IDX_BITS) begin : g_bad_napot
      $error("NAPOT_LOG out of range");
   end

   // Entry fields
   logic [PPN_W-1:0] ppn;
   logic [PPN_W-1:0] vpn;
   logic [PPN_W-1:0] shift_mask;
   logic [PPN_W-1:0] napot_mask;
   logic             misaligned;
   logic             napot_bad;
   logic             memtype_set;
   fault_e           cause;
   logic             grant_rd, grant_wr, grant_ex;
   logic [PPN_W-1:0] page_num;
   logic [PA_W-1:0]  paddr_c;
   logic             unused_bits;

   assign ppn         = req_pte[PB_PPN_LO +: PPN_W];
   assign vpn         = PPN_W'(req_vaddr[VA_W-1:PAGE_SHIFT]);
   assign memtype_set = |req_pte[PB_MT_LO +: MT_W];
   assign unused_bits = ^{req_pte[PB_PPN_LO-1:PB_D+1], req_pte[PB_D-1:PB_U+1],
                          req_pte[PB_V], req_pte[PB_MT_LO-1:PB_PPN_LO+PPN_W],
                          req_pte[PTE_W-1:PB_N]};

   pte_leaf_align #(
      .PPN_W    (PPN_W),
      .IDX_BITS (IDX_BITS),
      .LEVELS   (LEVELS)
   ) u_align (
      .ppn        (ppn),
      .level      (req_level),
      .shift_mask (shift_mask),
      .misaligned (misaligned)
   );

   pte_leaf_napot #(
      .PPN_W     (PPN_W),
      .LEVELS    (LEVELS),
      .NAPOT_LOG (NAPOT_LOG),
      .NAPOT_EN  (NAPOT_EN)
   ) u_napot (
      .ppn        (ppn),
      .level      (req_level),
      .n_bit      (req_pte[PB_N]),
      .napot_bad  (napot_bad),
      .napot_mask (napot_mask)
   );

   pte_leaf_rules u_rules (
      .bit_r       (req_pte[PB_R]),
      .bit_w       (req_pte[PB_W]),
      .bit_x       (req_pte[PB_X]),
      .bit_u       (req_pte[PB_U]),
      .bit_d       (req_pte[PB_D]),
      .memtype_set (memtype_set),
      .memtype_ok  (req_memtype_ok),
      .acc         (req_acc),
      .smode       (req_smode),
      .sum         (req_sum),
      .mxr         (req_mxr),
      .misaligned  (misaligned),
      .napot_bad   (napot_bad),
      .cause       (cause),
      .grant_rd    (grant_rd),
      .grant_wr    (grant_wr),
      .grant_ex    (grant_ex)
   );

   // Physical address assembly
   assign page_num = (ppn & ~napot_mask) | (vpn & napot_mask) | (vpn & shift_mask);
   assign paddr_c  = {page_num, req_vaddr[PAGE_SHIFT-1:0]};

   // Result register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_cause <= '0;
         rsp_paddr <= '0;
         rsp_rd    <= 1'b0;
         rsp_wr    <= 1'b0;
         rsp_ex    <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault <= (cause != FLT_NONE);
            rsp_cause <= cause;
            if (cause == FLT_NONE) begin
               rsp_paddr <= paddr_c;
               rsp_rd    <= grant_rd;
               rsp_wr    <= grant_wr;
               rsp_ex    <= grant_ex;
            end else begin
               rsp_paddr <= '0;
               rsp_rd    <= 1'b0;
               rsp_wr    <= 1'b0;
               rsp_ex    <= 1'b0;
            end
         end
      end
   end

   // Input legality taken for granted
   acc_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_acc != 2'b11));
   level_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_level < LVL_W'(LEVELS)));

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause)));
   // R12
   fault_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_rd && !rsp_wr && !rsp_ex));
   // R11
   wr_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_wr) |-> ($past(req_pte[PB_W]) &&
                                 ($past(req_acc) == ACC_STORE || $past(req_pte[PB_D]))));
   // R11
   ex_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ex) |-> $past(req_pte[PB_X]));
   // R7
   load_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault && $past(req_acc) == ACC_LOAD) |-> rsp_rd);
   // R7
   store_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault && $past(req_acc) == ACC_STORE) |-> rsp_wr);
   // R10
   offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |->
         (rsp_paddr[PAGE_SHIFT-1:0] == $past(req_vaddr[PAGE_SHIFT-1:0])));
   // R3
   memtype_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |->
         ($past(req_memtype_ok) || $past(req_pte[PB_MT_LO +: MT_W]) == '0));

endmodule

// File: tb/tb_pte_leaf_checker.sv
module tb_pte_leaf_checker;

   typedef struct {
      bit          flt;
      int          cause;
      logic [55:0] pa;
      bit          r, w, x;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_pte = '0;
   logic [1:0]  req_level = '0;
   logic [38:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_smode = 1'b0;
   logic        req_sum = 1'b0;
   logic        req_mxr = 1'b0;
   logic        req_memtype_ok = 1'b0;
   logic        rsp_valid, rsp_fault, rsp_rd, rsp_wr, rsp_ex;
   logic [3:0]  rsp_cause;
   logic [55:0] rsp_paddr;

   int    errors = 0;
   int    checks = 0;
   bit    exp_v = 1'b0;
   exp_t  exp_r;
   string cur_tag = "R1";
   logic [55:0] last_pa = '0;

   localparam logic [7:0] F_V = 8'h01, F_R = 8'h02, F_W = 8'h04, F_X = 8'h08,
                          F_U = 8'h10, F_D = 8'h80;

   always #2 clk = ~clk;

   pte_leaf_checker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
      .req_level(req_level), .req_vaddr(req_vaddr), .req_acc(req_acc),
      .req_smode(req_smode), .req_sum(req_sum), .req_mxr(req_mxr),
      .req_memtype_ok(req_memtype_ok), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd),
      .rsp_wr(rsp_wr), .rsp_ex(rsp_ex)
   );

   function automatic logic [63:0] mk(logic [63:0] ppn, logic [7:0] fl, int mt, bit n);
      logic [63:0] p;
      p = (ppn & ((64'd1 << 44) - 1)) << 10;
      p[7:0] = fl;
      p[62:61] = 2'(mt);
      p[63] = n;
      return p;
   endfunction

   function automatic exp_t model(logic [63:0] pte, int lvl, logic [38:0] va, int acc,
                                  bit s, bit sum, bit mxr, bit mtok);
      exp_t e;
      logic [63:0] ppn, vpn, smask, nmask, page;
      int sh, tz;
      bit pr, pw, px, pu, pd, pn;
      ppn = (pte >> 10) & ((64'd1 << 44) - 1);
      vpn = 64'(va) >> 12;
      sh = (2 - lvl) * 9;
      smask = (64'd1 << sh) - 1;
      pr = pte[1]; pw = pte[2]; px = pte[3]; pu = pte[4]; pd = pte[7]; pn = pte[63];
      tz = 0;
      while (tz < 44 && !ppn[tz]) tz++;
      nmask = pn ? 64'd15 : 64'd0;
      e.cause = 0;
      if ((ppn & smask) != 0) e.cause = 1;
      else if (pte[62:61] != 0 && !mtok) e.cause = 2;
      else if (!pr && pw && !px) e.cause = 3;
      else if (!pr && pw && px) e.cause = 4;
      else if (pu && s && !(sum && acc != 2)) e.cause = 5;
      else if (!pu && !s) e.cause = 6;
      else if (acc == 0 && !(pr || (px && mxr))) e.cause = 7;
      else if (acc == 1 && !pw) e.cause = 8;
      else if (acc == 2 && !px) e.cause = 9;
      else if (pn && (tz + 1 != 4 || lvl != 2)) e.cause = 10;
      e.flt = (e.cause != 0);
      e.pa = '0; e.r = 0; e.w = 0; e.x = 0;
      if (!e.flt) begin
         page = (ppn & ~nmask) | (vpn & nmask) | (vpn & smask);
         e.pa = 56'((page << 12) | 64'(va[11:0]));
         e.r = pr || (px && mxr);
         e.x = px;
         e.w = pw && (acc == 1 || pd);
      end
      return e;
   endfunction

   task automatic check_out();
      checks++;
      if (exp_v) begin
         if (rsp_valid !== 1'b1 || rsp_fault !== exp_r.flt || int'(rsp_cause) != exp_r.cause ||
             rsp_paddr !== exp_r.pa || rsp_rd !== exp_r.r || rsp_wr !== exp_r.w ||
             rsp_ex !== exp_r.x) begin
            errors++;
            $display("FAIL %s: got v=%0b f=%0b c=%0d pa=%h r%0b w%0b x%0b exp v=1 f=%0b c=%0d pa=%h r%0b w%0b x%0b",
                     cur_tag, rsp_valid, rsp_fault, rsp_cause, rsp_paddr, rsp_rd, rsp_wr, rsp_ex,
                     exp_r.flt, exp_r.cause, exp_r.pa, exp_r.r, exp_r.w, exp_r.x);
         end
         last_pa = exp_r.pa;
      end else begin
         // R1: no response and held outputs while idle
         if (rsp_valid !== 1'b0 || rsp_paddr !== last_pa) begin
            errors++;
            $display("FAIL R1 idle: got v=%0b pa=%h exp v=0 pa=%h", rsp_valid, rsp_paddr, last_pa);
         end
      end
   endtask

   task automatic step(bit v, logic [63:0] pte, int lvl, logic [38:0] va, int acc,
                       bit s, bit sum, bit mxr, bit mtok, string tag);
      @(negedge clk);
      check_out();
      req_valid = v; req_pte = pte; req_level = 2'(lvl); req_vaddr = va;
      req_acc = 2'(acc); req_smode = s; req_sum = sum; req_mxr = mxr; req_memtype_ok = mtok;
      exp_v = v;
      cur_tag = tag;
      if (v) exp_r = model(pte, lvl, va, acc, s, sum, mxr, mtok);
   endtask

   task automatic idle();
      step(1'b0, '0, 0, '0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: got running exp finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [38:0] va;
      va = 39'h2A_BCDE_F123;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_cause !== 4'd0 || rsp_paddr !== '0) begin
         errors++;
         $display("FAIL R1 reset: got v=%0b f=%0b c=%0d exp 0 0 0", rsp_valid, rsp_fault, rsp_cause);
      end
      rst_n = 1'b1;
      idle();
      // R7 / R11 load pass on readable page, supervisor
      step(1, mk(64'h12345, F_V|F_R, 0, 0), 2, va, 0, 1, 0, 0, 0, "R7");
      // R2 misaligned superpage at level 1, then aligned superpage (R10)
      step(1, mk(64'h12301, F_V|F_R, 0, 0), 1, va, 0, 1, 0, 0, 0, "R2");
      step(1, mk(64'h12200, F_V|F_R, 0, 0), 1, va, 0, 1, 0, 0, 0, "R10");
      step(1, mk(64'h40000, F_V|F_R|F_X, 0, 0), 0, va, 2, 1, 0, 0, 0, "R10");
      // R3 memory type
      step(1, mk(64'h777, F_V|F_R, 1, 0), 2, va, 0, 1, 0, 0, 0, "R3");
      step(1, mk(64'h777, F_V|F_R, 1, 0), 2, va, 0, 1, 0, 0, 1, "R3");
      // R4 reserved encodings
      step(1, mk(64'h55, F_V|F_W, 0, 0), 2, va, 1, 1, 0, 0, 0, "R4");
      step(1, mk(64'h55, F_V|F_W|F_X, 0, 0), 2, va, 1, 1, 0, 0, 0, "R4");
      // R5 user page in S mode
      step(1, mk(64'h66, F_V|F_R|F_U, 0, 0), 2, va, 0, 1, 0, 0, 0, "R5");
      step(1, mk(64'h66, F_V|F_R|F_U, 0, 0), 2, va, 0, 1, 1, 0, 0, "R5");
      step(1, mk(64'h66, F_V|F_X|F_U, 0, 0), 2, va, 2, 1, 1, 0, 0, "R5");
      step(1, mk(64'h66, F_V|F_X|F_U, 0, 0), 2, va, 2, 0, 0, 0, 0, "R5");
      // R6 supervisor page in U mode
      step(1, mk(64'h67, F_V|F_R, 0, 0), 2, va, 0, 0, 0, 0, 0, "R6");
      // R7 permissions per access
      step(1, mk(64'h68, F_V|F_X, 0, 0), 2, va, 0, 1, 0, 0, 0, "R7");
      step(1, mk(64'h68, F_V|F_X, 0, 0), 2, va, 0, 1, 0, 1, 0, "R7");
      step(1, mk(64'h68, F_V|F_R, 0, 0), 2, va, 1, 1, 0, 0, 0, "R7");
      step(1, mk(64'h68, F_V|F_R, 0, 0), 2, va, 2, 1, 0, 0, 0, "R7");
      idle();
      idle();
      // R8 NAPOT
      step(1, mk(64'hABC8, F_V|F_R, 0, 1), 2, va, 0, 1, 0, 0, 0, "R8");
      step(1, mk(64'hABC0, F_V|F_R, 0, 1), 2, va, 0, 1, 0, 0, 0, "R8");
      step(1, mk(64'hAB000, F_V|F_R, 0, 1), 1, va, 0, 1, 0, 0, 0, "R8");
      // R9 overlapping faults
      step(1, mk(64'hAB008, F_V|F_W, 1, 1), 1, va, 2, 0, 0, 0, 0, "R9");
      step(1, mk(64'h100, F_V|F_W, 3, 0), 2, va, 0, 0, 0, 0, 0, "R9");
      step(1, mk(64'h100, F_V|F_X|F_U, 0, 1), 2, va, 1, 1, 0, 0, 1, "R9");
      // R11 write grant rules
      step(1, mk(64'h200, F_V|F_R|F_W, 0, 0), 2, va, 1, 1, 0, 0, 0, "R11");
      step(1, mk(64'h200, F_V|F_R|F_W, 0, 0), 2, va, 0, 1, 0, 0, 0, "R11");
      step(1, mk(64'h200, F_V|F_R|F_W|F_D, 0, 0), 2, va, 0, 1, 0, 0, 0, "R11");
      // R12 fault zeroes address and grants after a pass
      step(1, mk(64'h201, F_V|F_R|F_W|F_X, 0, 0), 1, va, 0, 1, 0, 0, 0, "R12");
      idle();
      // R9 random mix
      for (int k = 0; k < 600; k++) begin
         logic [63:0] ppn;
         logic [7:0]  fl;
         int          lvl, acc, mt;
         bit          n;
         if ($urandom_range(0, 9) == 0) begin
            idle();
            continue;
         end
         ppn = {$urandom, $urandom};
         ppn = ppn & ~((64'd1 << $urandom_range(0, 20)) - 1);
         if ($urandom_range(0, 3) == 0) ppn[3:0] = 4'b1000;
         fl = F_V | 8'(($urandom_range(1, 7)) << 1);
         if ($urandom_range(0, 1) == 1) fl = fl | F_U;
         if ($urandom_range(0, 1) == 1) fl = fl | F_D;
         lvl = $urandom_range(0, 2);
         acc = $urandom_range(0, 2);
         mt = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
         n = ($urandom_range(0, 3) == 0);
         step(1, mk(ppn, fl, mt, n), lvl, {$urandom, $urandom}, acc, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R9");
      end
      idle();
      idle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule